// File: doc/BRIEF.md
# Nibble-wide serial RTC register master

This block is the host-side engine for a real-time-clock chip whose registers are four bits wide and reached over a three-wire serial link. The link has a chip enable, a serial clock, and a single data line that both sides share. A local request port carries the operation, a 4-bit register address and, for writes, a 4-bit value. The block shifts out a 16-bit frame and turns the shared line around when a read needs it. It returns the read nibble together with a one-cycle completion pulse.

The shared data line appears as three signals: a driven value, an output enable and a sampled input. A pad or a behavioural slave can be attached to them. The serial clock is derived from the system clock by a parameterised half-period divider. A caller that needs several accesses under one chip-enable window holds the `burst_hold` input high for the whole burst. Decoding register contents, time conversion and retrying are left to the caller.

Top module: `nibble_rtc_master`

## Requirements
- R1: After reset, `busy`, `done`, `rtc_sclk` and `rtc_doe` are low, and `rtc_ce` is low while `burst_hold` is low.
- R2: A read (`req_write`=0) shifts out the command bits 1,1,1,0 and then the address bits 3 down to 0. Each bit is placed on `rtc_dout` while `rtc_sclk` is low.
- R3: `rtc_doe` is high from the first bit of every access. In a read it drops after bit slot 7 and stays low for the remaining eight slots. In a write it stays high for all 16 slots. It is low whenever no access is running.
- R4: In a read, the first four bits received after the turnaround are discarded. The next four are sampled from `rtc_din` on rising edges of `rtc_sclk`, most significant bit first. They appear on `rdata` when `done` pulses and are held until the next accepted request.
- R5: A write shifts out 1,0,1,0, then the address bits 3 down to 0, then 1,0,0,1, then the data bits 3 down to 0.
- R6: `rtc_sclk` idles low. Every access produces exactly 16 rising edges, and each half-period lasts `HALF_DIV` system clock cycles.
- R7: `done` is a single-cycle pulse raised exactly 32×`HALF_DIV` cycles after the edge that accepts the request. `busy` is high from the cycle after acceptance until `done` rises.
- R8: A request raised while `busy` is high is ignored. It produces no extra serial clock edges and changes no register in the chip.
- R9: While idle, `rtc_ce` follows `burst_hold` one cycle later. During an access it is forced high for every serial clock edge, whatever `burst_hold` does.
- R10: `rtc_dout` does not change while `rtc_sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 4 | Register address |
| req_wdata | input | 4 | Write value |
| burst_hold | input | 1 | Caller-held chip-enable window |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 4 | Read result, valid with `done` |
| rtc_ce | output | 1 | Chip enable to the clock chip |
| rtc_sclk | output | 1 | Serial clock |
| rtc_dout | output | 1 | Value driven onto the shared data line |
| rtc_doe | output | 1 | Drive enable for the shared data line |
| rtc_din | input | 1 | Value sampled from the shared data line |

## Verification
Any corrupted state in the bit counter or the phase flag moves the `done` pulse away from 32×`HALF_DIV` cycles and changes the number of serial clock edges. The bench counts both on every access, so such a fault shows at the first access. A slip in the turnaround point shows as a drive-enable mismatch in slot 7 or 8 of a read. A capture that starts at the wrong bit takes in the all-ones filler the slave drives during the discarded slots. That is visible on `rdata` at the very next read of a register whose value has zeros in it. A request that leaks in while busy shows up as 32 serial clock edges instead of 16, or as a changed register on the following read-back.

// File: rtl/nrm_pkg.sv
package nrm_pkg;

    localparam int NIB_W      = 4;
    localparam int FRAME_BITS = 16;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TURN_SLOT  = 8;   // first slot with the line released in a read
    localparam int CAPT_SLOT  = 12;  // first slot whose input bit is kept

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [NIB_W-1:0] addr;
        logic [NIB_W-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic                  busy;
        logic                  high_half;
        logic [IDX_W-1:0]      slot;
        logic [FRAME_BITS-1:0] shreg;
        op_e                   op;
    } seq_t;

    // command nibbles: don't-care, read/not-write, address phase, data phase
    localparam logic [NIB_W-1:0] CMD_RD_ADDR = 4'b1110;
    localparam logic [NIB_W-1:0] CMD_WR_ADDR = 4'b1010;
    localparam logic [NIB_W-1:0] CMD_WR_DATA = 4'b1001;

    function automatic logic [FRAME_BITS-1:0] frame_of(req_t r);
        if (r.op == OP_WRITE)
            return {CMD_WR_ADDR, r.addr, CMD_WR_DATA, r.wdata};
        return {CMD_RD_ADDR, r.addr, {(2*NIB_W){1'b0}}};
    endfunction

    function automatic logic slot_driven(op_e op, logic [IDX_W-1:0] slot);
        return (op == OP_WRITE) || (slot < IDX_W'(TURN_SLOT));
    endfunction

endpackage

// File: rtl/nrm_halfper.sv
module nrm_halfper #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    generate
        if (HALF_DIV == 1) begin : g_every
            always_ff @(posedge clk) cnt <= '0;
            assign tick = run;
        end else begin : g_count
            always_ff @(posedge clk) begin
                if (rst || !run)    cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                cnt <= cnt + 1'b1;
            end
            assign tick = run && (cnt == LAST);
        end
    endgenerate

endmodule

// File: rtl/nrm_capture.sv
module nrm_capture
    import nrm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             din,
    output logic [NIB_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst || clear) rdata <= '0;
        else if (shift_en) rdata <= {rdata[NIB_W-2:0], din};
    end
endmodule

// File: rtl/nrm_sequencer.sv
module nrm_sequencer
    import nrm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  op_e                   start_op,
    input  logic [FRAME_BITS-1:0] start_frame,
    input  logic                  tick,
    output logic                  busy,
    output logic                  done,
    output logic                  sclk,
    output logic                  dout,
    output logic                  doe,
    output logic                  sample_en
);
    seq_t st;
    logic last_slot;

    assign busy      = st.busy;
    assign last_slot = (st.slot == IDX_W'(FRAME_BITS - 1));
    assign sample_en = st.busy && tick && !st.high_half && (st.op == OP_READ)
                       && (st.slot >= IDX_W'(CAPT_SLOT));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            done <= 1'b0;
            sclk <= 1'b0;
            dout <= 1'b0;
            doe  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!st.busy) begin
                if (start) begin
                    st.busy      <= 1'b1;
                    st.high_half <= 1'b0;
                    st.slot      <= '0;
                    st.shreg     <= start_frame;
                    st.op        <= start_op;
                    dout         <= start_frame[FRAME_BITS-1];
                    doe          <= 1'b1;
                end
            end else if (tick) begin
                if (!st.high_half) begin
                    st.high_half <= 1'b1;
                    sclk         <= 1'b1;
                end else begin
                    st.high_half <= 1'b0;
                    sclk         <= 1'b0;
                    if (last_slot) begin
                        st.busy <= 1'b0;
                        done    <= 1'b1;
                        doe     <= 1'b0;
                        dout    <= 1'b0;
                    end else begin
                        st.slot  <= st.slot + 1'b1;
                        st.shreg <= {st.shreg[FRAME_BITS-2:0], 1'b0};
                        dout     <= st.shreg[FRAME_BITS-2];
                        doe      <= slot_driven(st.op, st.slot + 1'b1);
                    end
                end
            end
        end
    end

    a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
        !st.busy |-> !sclk);
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!st.busy && $past(st.busy)));
    a_r10_dout_stable_high: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(dout));
    a_r3_drive_only_in_access: assert property (@(posedge clk) disable iff (rst)
        doe |-> st.busy);

endmodule

// File: rtl/nibble_rtc_master.sv
module nibble_rtc_master
    import nrm_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [NIB_W-1:0] req_addr,
    input  logic [NIB_W-1:0] req_wdata,
    input  logic             burst_hold,
    output logic             busy,
    output logic             done,
    output logic [NIB_W-1:0] rdata,
    output logic             rtc_ce,
    output logic             rtc_sclk,
    output logic             rtc_dout,
    output logic             rtc_doe,
    input  logic             rtc_din
);
    req_t req;
    logic accept;
    logic tick;
    logic sample_en;
    logic ce_q;

    assign req.op    = req_write ? OP_WRITE : OP_READ;
    assign req.addr  = req_addr;
    assign req.wdata = req_wdata;
    assign accept    = req_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst) ce_q <= 1'b0;
        else     ce_q <= burst_hold;
    end
    assign rtc_ce = ce_q || busy;

    nrm_halfper #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    nrm_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .start_op    (req.op),
        .start_frame (frame_of(req)),
        .tick        (tick),
        .busy        (busy),
        .done        (done),
        .sclk        (rtc_sclk),
        .dout        (rtc_dout),
        .doe         (rtc_doe),
        .sample_en   (sample_en)
    );

    nrm_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .shift_en (sample_en),
        .din      (rtc_din),
        .rdata    (rdata)
    );

    a_r9_ce_on_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(rtc_sclk) |-> rtc_ce);
    a_r8_busy_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && req_valid) |=> ($past(rtc_sclk) || !rtc_sclk || busy));

endmodule

// File: tb/sim_nibble_rtc_master.sv
module sim_nibble_rtc_master;
    localparam int H = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, burst_hold = 1'b0;
    logic [3:0] req_addr = '0, req_wdata = '0;
    logic busy, done, rtc_ce, rtc_sclk, rtc_dout, rtc_doe;
    logic rtc_din = 1'b0;
    logic [3:0] rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    nibble_rtc_master #(.HALF_DIV(H)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .burst_hold(burst_hold),
        .busy(busy), .done(done), .rdata(rdata), .rtc_ce(rtc_ce),
        .rtc_sclk(rtc_sclk), .rtc_dout(rtc_dout), .rtc_doe(rtc_doe),
        .rtc_din(rtc_din)
    );

    function automatic logic [3:0] init_val(int a);
        return 4'(a) ^ 4'h5;
    endfunction

    // behavioural slave: records each slot on the rising serial edge
    logic [3:0] mem_s [16];
    logic cap_dout [16];
    logic cap_doe  [16];
    logic cap_ce   [16];
    int   rises = 0;
    logic sclk_prev = 1'b0;

    initial for (int i = 0; i < 16; i++) mem_s[i] = init_val(i);

    always @(negedge clk) begin
        if (rtc_sclk && !sclk_prev) begin
            automatic int i = rises % 16;
            cap_dout[i] = rtc_dout;
            cap_doe[i]  = rtc_doe;
            cap_ce[i]   = rtc_ce;
            rises = rises + 1;
            if (i == 15 && cap_dout[1] == 1'b0)
                mem_s[{cap_dout[4], cap_dout[5], cap_dout[6], cap_dout[7]}] =
                    {cap_dout[12], cap_dout[13], cap_dout[14], cap_dout[15]};
        end
        sclk_prev = rtc_sclk;
        if (!rtc_sclk) begin
            automatic int i = rises % 16;
            if (i >= 12) begin
                automatic logic [3:0] v =
                    mem_s[{cap_dout[4], cap_dout[5], cap_dout[6], cap_dout[7]}];
                rtc_din = v[15 - i];
            end else if (i >= 8) rtc_din = 1'b1;
            else rtc_din = 1'($urandom % 2);
        end
    end

    logic [3:0] exp_mem [16];

    function automatic logic [15:0] exp_frame(logic wr, logic [3:0] a, logic [3:0] d);
        if (wr) return {1'b1, 1'b0, 1'b1, 1'b0, a, 1'b1, 1'b0, 1'b0, 1'b1, d};
        return {1'b1, 1'b1, 1'b1, 1'b0, a, 8'h00};
    endfunction

    task automatic check(logic ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(logic wr, logic [3:0] a, logic [3:0] d, logic inject);
        int k;
        int r0;
        int bad_drive, bad_bit, bad_ce;
        logic [15:0] f;
        f = exp_frame(wr, a, d);
        r0 = rises;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        while (k < 1000) begin
            @(posedge clk); k++;
            @(negedge clk);
            if (inject && k == 5) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = ~a; req_wdata = ~d;
            end else req_valid = 1'b0;
            if (done) break;
        end
        req_valid = 1'b0;
        check(k == 32*H, "R7 done latency", k, 32*H);
        check(!busy, "R7 busy low at done", int'(busy), 0);
        check(rises - r0 == 16, "R6 edges per access", rises - r0, 16);
        bad_drive = 0; bad_bit = 0; bad_ce = 0;
        for (int i = 0; i < 16; i++) begin
            automatic logic drv = wr || (i < 8);
            if (cap_doe[i] !== drv) bad_drive++;
            if (drv && cap_dout[i] !== f[15 - i]) bad_bit++;
            if (cap_ce[i] !== 1'b1) bad_ce++;
        end
        check(bad_drive == 0, "R3 drive enable per slot", bad_drive, 0);
        check(bad_bit == 0, wr ? "R5 write frame bits" : "R2 read frame bits", bad_bit, 0);
        check(bad_ce == 0, "R9 ce high on every edge", bad_ce, 0);
        if (wr) exp_mem[a] = d;
        else check(rdata == exp_mem[a], "R4 read data", int'(rdata), int'(exp_mem[a]));
        if (inject) begin
            repeat (40*H) @(negedge clk);
            check(rises - r0 == 16 && !busy, "R8 request while busy ignored",
                  rises - r0, 16);
        end
        @(negedge clk);
        check(!rtc_sclk && !rtc_doe, "R6 R3 idle after access",
              int'({rtc_sclk, rtc_doe}), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        for (int i = 0; i < 16; i++) exp_mem[i] = init_val(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !rtc_sclk && !rtc_doe && !rtc_ce, "R1 reset state",
              int'({busy, done, rtc_sclk, rtc_doe, rtc_ce}), 0);

        // chip-enable window while idle
        burst_hold = 1'b1;
        @(negedge clk);
        check(rtc_ce, "R9 ce follows hold", int'(rtc_ce), 1);
        burst_hold = 1'b0;
        @(negedge clk);
        check(!rtc_ce, "R9 ce released", int'(rtc_ce), 0);

        // directed corner cases
        access(1'b1, 4'h0, 4'h0, 1'b0);
        access(1'b0, 4'h0, 4'h0, 1'b0);   // dummy slots drive ones: must read 0
        access(1'b1, 4'hF, 4'hF, 1'b0);
        access(1'b0, 4'hF, 4'hF, 1'b0);
        access(1'b0, 4'h9, 4'h0, 1'b0);   // never written: initial value
        access(1'b1, 4'h3, 4'h6, 1'b0);
        access(1'b0, 4'h6, 4'h0, 1'b1);   // foreign write to addr 9 injected
        access(1'b0, 4'h9, 4'h0, 1'b0);   // R8: addr 9 unchanged
        burst_hold = 1'b1;
        access(1'b1, 4'h7, 4'hA, 1'b0);
        access(1'b0, 4'h7, 4'h0, 1'b0);
        check(rtc_ce, "R9 ce held between burst accesses", int'(rtc_ce), 1);
        burst_hold = 1'b0;

        // random mix
        for (int n = 0; n < 60; n++) begin
            burst_hold = 1'($urandom % 2);
            access(1'($urandom % 2), 4'($urandom), 4'($urandom), 1'($urandom % 8 == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule